// File: doc/BRIEF.md
# Same-Line Response/Snoop Ordering Monitor

This block watches one master port of a coherent interconnect and checks that responses and snoops aimed at the same cache line are handed to the master in a legal order. It receives single-cycle strobes, each with an address: transaction responses given to the master, the master's read and write acknowledges, snoop requests sent to the master, and the master's snoop responses. Responses also carry a transaction-kind code. A small table of line tags records, for each line, whether an acknowledge or a snoop response is still owed.

Two cross-ordering rules are checked. A snoop must not reach a line whose response is still waiting for its acknowledge. A response must not reach a line whose snoop is still waiting for its snoop response. Write-back and write-clean responses are exempt, because the master may hold a snoop until such a write has completed. A breach sets a sticky two-bit code, and table exhaustion sets a sticky overflow flag. A synchronous clear resets both.

Top module: `line_order_monitor`

## Requirements
- R1: Addresses are compared by cache line: two addresses match when they agree above the lowest LINE_OFS bits (default 6, a 64-byte line). With the defaults, 0x1000 and 0x103F match, and 0x1000 and 0x1040 do not.
- R2: A snoop to a line that still owes an acknowledge for an earlier response sets `viol_code[0]` (snoop before acknowledge).
- R3: A non-exempt response to a line that still owes a snoop response sets `viol_code[1]` (response before snoop response).
- R4: `rsp_kind` is 2 bits: 00 read, 01 write, 10 write-back, 11 write-clean. A read response is released only by `rack_vld` and a write response only by `wack_vld`. An acknowledge of the other type, or to another line, has no effect.
- R5: Write-back (10) and write-clean (11) responses never set a violation, even while a snoop to the line is pending, and they are not tracked. A later snoop to that line is therefore legal.
- R6: Once the acknowledge has been received, a snoop to that line is legal (the transaction was ordered first). Once the snoop response has been received, a response to that line is legal (the snoop was ordered first).
- R7: Events that arrive in the same cycle are applied in this order: acknowledges, then snoop responses, then responses, then snoops. A response and a snoop to one line in the same cycle set `viol_code[0]`. An acknowledge together with a snoop, or a snoop response together with a response, sets nothing.
- R8: `viol_code` bits and `ovf` are sticky. `clr` zeroes them on the next edge, but a violation detected in the same cycle as `clr` is still recorded. `viol` is high exactly when `viol_code` is non-zero.
- R9: When a new line must be tracked and all ENTRIES slots (default 8) are in use, `ovf` is set and the event is dropped, so that line is not tracked.
- R10: After reset, `viol`, `viol_code` and `ovf` are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the sticky flags |
| rsp_vld | input | 1 | Response given to the master |
| rsp_addr | input | AW | Response address |
| rsp_kind | input | 2 | Response kind: 00 read, 01 write, 10 write-back, 11 write-clean |
| rack_vld | input | 1 | Read acknowledge from the master |
| rack_addr | input | AW | Read acknowledge address |
| wack_vld | input | 1 | Write acknowledge from the master |
| wack_addr | input | AW | Write acknowledge address |
| snp_vld | input | 1 | Snoop sent to the master |
| snp_addr | input | AW | Snoop address |
| cr_vld | input | 1 | Snoop response from the master |
| cr_addr | input | AW | Snoop response address |
| viol | output | 1 | Any violation recorded |
| viol_code | output | 2 | Bit 0: snoop before acknowledge; bit 1: response before snoop response |
| ovf | output | 1 | Table overflow recorded |

## Verification
Two functions can fall in the same cycle: release of a pending item (acknowledge or snoop response) and arrival of a new item on the same line (snoop or response). A third case is a response and a snoop arriving together on one line. The bench raises each pair on a single clock edge. It expects no violation when the release comes first in the fixed order, and `viol_code` 01 when the response and the snoop arrive together. A further case raises a new violation in the same cycle as the clear and expects the flag to remain set.

// File: rtl/line_order_monitor.sv
module line_order_monitor #(
  parameter int AW       = 32,
  parameter int LINE_OFS = 6,
  parameter int ENTRIES  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rsp_vld,
  input  logic [AW-1:0] rsp_addr,
  input  logic [1:0]    rsp_kind,
  input  logic          rack_vld,
  input  logic [AW-1:0] rack_addr,
  input  logic          wack_vld,
  input  logic [AW-1:0] wack_addr,
  input  logic          snp_vld,
  input  logic [AW-1:0] snp_addr,
  input  logic          cr_vld,
  input  logic [AW-1:0] cr_addr,
  output logic          viol,
  output logic [1:0]    viol_code,
  output logic          ovf
);
  localparam int TW = AW - LINE_OFS;

  logic [TW-1:0] tag_q   [ENTRIES];
  logic          ack_q   [ENTRIES];
  logic          wr_q    [ENTRIES];
  logic          cr_q    [ENTRIES];
  logic [TW-1:0] tag_d   [ENTRIES];
  logic          ack_d   [ENTRIES];
  logic          wr_d    [ENTRIES];
  logic          cr_d    [ENTRIES];
  logic [1:0]    code_new;
  logic          ovf_new;
  logic          hit, placed;
  logic [1:0]    code_q;
  logic          ovf_q;

  wire [TW-1:0] rsp_line  = rsp_addr[AW-1:LINE_OFS];
  wire [TW-1:0] rack_line = rack_addr[AW-1:LINE_OFS];
  wire [TW-1:0] wack_line = wack_addr[AW-1:LINE_OFS];
  wire [TW-1:0] snp_line  = snp_addr[AW-1:LINE_OFS];
  wire [TW-1:0] cr_line   = cr_addr[AW-1:LINE_OFS];
  wire          rsp_track = rsp_vld && !rsp_kind[1];

  always_comb begin
    code_new = '0;
    ovf_new  = 1'b0;
    hit      = 1'b0;
    placed   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      tag_d[i] = tag_q[i];
      ack_d[i] = ack_q[i];
      wr_d[i]  = wr_q[i];
      cr_d[i]  = cr_q[i];
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (rack_vld && ack_d[i] && !wr_d[i] && tag_d[i] == rack_line) ack_d[i] = 1'b0;
      if (wack_vld && ack_d[i] &&  wr_d[i] && tag_d[i] == wack_line) ack_d[i] = 1'b0;
    end
    for (int i = 0; i < ENTRIES; i++)
      if (cr_vld && cr_d[i] && tag_d[i] == cr_line) cr_d[i] = 1'b0;
    if (rsp_track) begin
      for (int i = 0; i < ENTRIES; i++)
        if ((ack_d[i] || cr_d[i]) && tag_d[i] == rsp_line) begin
          hit = 1'b1;
          if (cr_d[i]) code_new[1] = 1'b1;
          ack_d[i] = 1'b1;
          wr_d[i]  = rsp_kind[0];
        end
      if (!hit) begin
        for (int i = 0; i < ENTRIES; i++)
          if (!placed && !ack_d[i] && !cr_d[i]) begin
            placed   = 1'b1;
            tag_d[i] = rsp_line;
            ack_d[i] = 1'b1;
            wr_d[i]  = rsp_kind[0];
          end
        if (!placed) ovf_new = 1'b1;
      end
    end
    hit    = 1'b0;
    placed = 1'b0;
    if (snp_vld) begin
      for (int i = 0; i < ENTRIES; i++)
        if ((ack_d[i] || cr_d[i]) && tag_d[i] == snp_line) begin
          hit = 1'b1;
          if (ack_d[i]) code_new[0] = 1'b1;
          cr_d[i] = 1'b1;
        end
      if (!hit) begin
        for (int i = 0; i < ENTRIES; i++)
          if (!placed && !ack_d[i] && !cr_d[i]) begin
            placed   = 1'b1;
            tag_d[i] = snp_line;
            cr_d[i]  = 1'b1;
          end
        if (!placed) ovf_new = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ack_q[i] <= 1'b0;
        wr_q[i]  <= 1'b0;
        cr_q[i]  <= 1'b0;
      end
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= tag_d[i];
        ack_q[i] <= ack_d[i];
        wr_q[i]  <= wr_d[i];
        cr_q[i]  <= cr_d[i];
      end
      code_q <= (clr ? 2'b00 : code_q) | code_new;
      ovf_q  <= (clr ? 1'b0 : ovf_q) | ovf_new;
    end
  end

  assign viol_code = code_q;
  assign viol      = |code_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/line_order_monitor_chk.sv
module line_order_monitor_chk #(
  parameter int AW       = 32,
  parameter int LINE_OFS = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          rsp_vld,
  input logic [AW-1:0] rsp_addr,
  input logic [1:0]    rsp_kind,
  input logic          snp_vld,
  input logic [AW-1:0] snp_addr,
  input logic          viol,
  input logic [1:0]    viol_code,
  input logic          ovf
);
  AST_SAME_CYCLE_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_kind[1] && snp_vld &&
     rsp_addr[AW-1:LINE_OFS] == snp_addr[AW-1:LINE_OFS]) |=> viol_code[0]); // R7
  AST_EXEMPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol_code[1] && (!rsp_vld || rsp_kind[1])) |=> !viol_code[1]); // R5
  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !rsp_vld && !snp_vld) |=> $stable(viol_code)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rsp_vld && !snp_vld) |=> (viol_code == 2'b00 && !ovf)); // R8
  AST_VIOL_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 2'b00)); // R8
endmodule

bind line_order_monitor line_order_monitor_chk #(.AW(AW), .LINE_OFS(LINE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rsp_vld(rsp_vld), .rsp_addr(rsp_addr),
  .rsp_kind(rsp_kind), .snp_vld(snp_vld), .snp_addr(snp_addr),
  .viol(viol), .viol_code(viol_code), .ovf(ovf));

// File: tb/test_line_order_monitor.sv
module test_line_order_monitor;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic rsp_vld = 0, rack_vld = 0, wack_vld = 0, snp_vld = 0, cr_vld = 0;
  logic [31:0] rsp_addr = 0, rack_addr = 0, wack_addr = 0, snp_addr = 0, cr_addr = 0;
  logic [1:0] rsp_kind = 0;
  logic viol, ovf;
  logic [1:0] viol_code;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  line_order_monitor i_line_order_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rack_vld(rack_vld), .rack_addr(rack_addr),
    .wack_vld(wack_vld), .wack_addr(wack_addr),
    .snp_vld(snp_vld), .snp_addr(snp_addr),
    .cr_vld(cr_vld), .cr_addr(cr_addr),
    .viol(viol), .viol_code(viol_code), .ovf(ovf));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {viol,code,ovf}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rsp_vld = 0; rack_vld = 0; wack_vld = 0; snp_vld = 0; cr_vld = 0; clr = 0;
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 0;
    step();
    rst_n = 1;
  endtask

  task automatic rsp(input logic [31:0] a, input logic [1:0] k);
    rsp_vld = 1; rsp_addr = a; rsp_kind = k;
  endtask
  task automatic snp(input logic [31:0] a); snp_vld = 1; snp_addr = a; endtask
  task automatic cr(input logic [31:0] a); cr_vld = 1; cr_addr = a; endtask
  task automatic rack(input logic [31:0] a); rack_vld = 1; rack_addr = a; endtask
  task automatic wack(input logic [31:0] a); wack_vld = 1; wack_addr = a; endtask

  function automatic logic [3:0] st();
    return {viol, viol_code, ovf};
  endfunction

  task automatic t_reset();
    restart();
    chk("R10 reset", st(), 4'b0000);
  endtask

  task automatic t_granularity();
    restart();
    rsp(32'h1000, 2'b00); step();
    snp(32'h1040); step();
    chk("R1 next line", st(), 4'b0000);
    snp(32'h103F); step();
    chk("R1 same line", st(), 4'b1010);
  endtask

  task automatic t_snoop_before_ack();
    restart();
    rsp(32'h2000, 2'b01); step();
    snp(32'h2000); step();
    chk("R2 snoop before ack", st(), 4'b1010);
  endtask

  task automatic t_rsp_before_cr();
    restart();
    snp(32'h3000); step();
    rsp(32'h3000, 2'b00); step();
    chk("R3 response before snoop response", st(), 4'b1100);
  endtask

  task automatic t_ack_type();
    restart();
    rsp(32'h4000, 2'b00); step();
    wack(32'h4000); step();
    rack(32'h4040); step();
    snp(32'h4000); step();
    chk("R4 wrong ack type ignored", st(), 4'b1010);
    restart();
    rsp(32'h4000, 2'b01); step();
    wack(32'h4000); step();
    snp(32'h4000); step();
    chk("R4 write ack releases write", st(), 4'b0000);
  endtask

  task automatic t_exempt();
    restart();
    snp(32'h5000); step();
    rsp(32'h5000, 2'b10); step();
    chk("R5 write-back during snoop", st(), 4'b0000);
    rsp(32'h5000, 2'b11); step();
    chk("R5 write-clean during snoop", st(), 4'b0000);
    cr(32'h5000); step();
    rsp(32'h5100, 2'b10); step();
    snp(32'h5100); step();
    chk("R5 write-back not tracked", st(), 4'b0000);
  endtask

  task automatic t_ordering();
    restart();
    snp(32'h6000); step();
    cr(32'h6000); step();
    rsp(32'h6000, 2'b00); step();
    chk("R6 snoop ordered first", st(), 4'b0000);
    rack(32'h6000); step();
    snp(32'h6000); step();
    chk("R6 transaction ordered first", st(), 4'b0000);
  endtask

  task automatic t_same_cycle();
    restart();
    rsp(32'h7000, 2'b00); snp(32'h7000); step();
    chk("R7 response with snoop", st(), 4'b1010);
    restart();
    rsp(32'h7000, 2'b00); step();
    rack(32'h7000); snp(32'h7000); step();
    chk("R7 ack with snoop", st(), 4'b0000);
    cr(32'h7000); rsp(32'h7000, 2'b01); step();
    chk("R7 snoop response with response", st(), 4'b0000);
  endtask

  task automatic t_sticky();
    restart();
    rsp(32'h8000, 2'b00); step();
    snp(32'h8000); step();
    repeat (3) step();
    chk("R8 held", st(), 4'b1010);
    clr = 1; step();
    chk("R8 cleared", st(), 4'b0000);
    rsp(32'h8000, 2'b00); clr = 1; step();
    chk("R8 clear with new violation", st(), 4'b1100);
  endtask

  task automatic t_overflow();
    restart();
    for (int i = 0; i < 8; i++) begin
      rsp(32'h9000 + 32'(i) * 32'h40, 2'b00); step();
    end
    chk("R9 table full no flag", st(), 4'b0000);
    rsp(32'hA000, 2'b00); step();
    chk("R9 overflow", st(), 4'b0001);
    rack(32'h9000); step();
    snp(32'hA000); step();
    chk("R9 dropped line untracked", st(), 4'b0001);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_granularity();
    t_snoop_before_ack();
    t_rsp_before_cr();
    t_ack_type();
    t_exempt();
    t_ordering();
    t_same_cycle();
    t_sticky();
    t_overflow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule